// File: doc/BRIEF.md
# Tri-State PWM Half-Bridge Sequencer

This block converts a three-level PWM command into the two gate enables of one synchronous buck phase: a high-side enable and a low-side enable. The PWM level arrives as two already-decoded flags; when neither flag is set, the level is in the middle band. A middle level that is held long enough switches the phase into diode emulation. In that mode the high side is off, and the low side conducts only until a zero-current comparator fires. After that the switch node floats.

Every switch-over between the two sides gets a programmable dead time, counted in clock cycles. A negative-overcurrent trip blanks the low side for a fixed number of cycles without raising any fault. An external fault-latched flag keeps the high side off and applies the diode-emulation rule to the low side. Enable low parks both switches. A controller places one instance per phase, between its PWM level decoder and the gate drivers.

Top module: `tri_pwm_phase_seq`

## Requirements
- R1: While `en` is sampled low at a rising edge, both `hs_on` and `ls_on` are low after that edge.
- R2: With `en` high and no fault, a high PWM level (`pwm_hi`=1) turns `hs_on` on and a low level (`pwm_lo`=1, `pwm_hi`=0) turns `ls_on` on. A switch whose opposite side has been off for at least the dead time turns on at the first rising edge that samples the level.
- R3: `hs_on` and `ls_on` are never high in the same cycle.
- R4: When the command moves from one side to the other, both enables stay low for exactly DEAD_CYC cycles between the falling of one and the rising of the other.
- R5: A middle level (both flags 0) seen on fewer than QUAL_CYC consecutive rising edges changes nothing. The outputs keep following the last high or low level, and the count restarts when the level returns.
- R6: A middle level seen on QUAL_CYC consecutive rising edges turns `hs_on` off at the last of those edges.
- R7: In diode emulation the low side turns on after the dead time and turns off at the edge that samples `zc_det` high. Both switches then stay off, even if `zc_det` falls again, until the PWM leaves the middle band.
- R8: `neg_oc` sampled high while `ls_on` is high turns `ls_on` off at that edge. It stays off for exactly BLANK_CYC cycles and then resumes, and no other output changes.
- R9: While `flt_latched` is high, `hs_on` is off after the next edge whatever the PWM level, and the low side follows the rule of R7. When the flag clears, normal PWM following resumes.
- R10: During reset both enables are low and `sw_hiz` is high.
- R11: If both PWM flags are set, the high level wins. Neither flag set is the middle band.
- R12: `sw_hiz` is high exactly when both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Phase enable; low parks both switches |
| pwm_hi | input | 1 | Decoded PWM high level |
| pwm_lo | input | 1 | Decoded PWM low level |
| zc_det | input | 1 | Inductor current has reached zero |
| neg_oc | input | 1 | Low-side negative current limit reached |
| flt_latched | input | 1 | External fault latch is set |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| sw_hiz | output | 1 | Switch node is floating (both switches off) |

## Verification
The bench holds a middle level for one edge less than the qualification count and then for the full count. A timer that is off by one would drop the high side one cycle early or late. The bench also pins the negative-current blank to its exact last cycle, and it steps through a side change one edge at a time. A blank or dead time of the wrong length, or an overlap, shows up at those edges. It checks that a zero-current event sticks while the comparator flag drops again, that the fault flag overrides a high PWM, and that both flags set resolve to the high side. A design that re-armed diode emulation or ignored the fault would switch the wrong side on.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  typedef enum logic [1:0] {
    LV_MID = 2'd0,
    LV_HI  = 2'd1,
    LV_LO  = 2'd2
  } lvl_e;

  // high wins over low; no flag means middle band
  function automatic lvl_e decode_lvl(input logic hi, input logic lo);
    if (hi)      return LV_HI;
    else if (lo) return LV_LO;
    else         return LV_MID;
  endfunction

endpackage

// File: rtl/tsq_midqual.sv
module tsq_midqual #(
  parameter int QUAL_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_now,
  output logic qual
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] RUN_TOP = QW'(QUAL_CYC - 1);

  logic [QW-1:0] run;

  function automatic logic [QW-1:0] run_next(input logic [QW-1:0] r, input logic m);
    if (!m)            return '0;
    else if (r != RUN_TOP) return r + 1'b1;
    else               return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= run_next(run, mid_now);
  end

  assign qual = mid_now && (run >= RUN_TOP);
endmodule

// File: rtl/tsq_nblank.sv
module tsq_nblank #(
  parameter int BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ls_on,
  input  logic neg_oc,
  output logic ls_kill
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic          trip;
  logic [BW-1:0] left;

  assign trip = ls_on && neg_oc;

  always_ff @(posedge clk) begin
    if (!rst_n)          left <= '0;
    else if (trip)       left <= BW'(BLANK_CYC - 1);
    else if (left != '0) left <= left - 1'b1;
  end

  assign ls_kill = trip || (left != '0);
endmodule

// File: rtl/tsq_gate.sv
module tsq_gate #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hs,
  input  logic want_ls,
  input  logic ls_kill,
  output logic hs_q,
  output logic ls_q
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] GAP_TOP = DW'(DEAD_CYC);

  logic [DW-1:0] hs_gap, ls_gap;

  function automatic logic [DW-1:0] gap_next(input logic [DW-1:0] g, input logic on);
    if (on)             return '0;
    else if (g != GAP_TOP) return g + 1'b1;
    else                return g;
  endfunction

  function automatic logic gap_done(input logic [DW-1:0] g);
    return g >= DW'(DEAD_CYC - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      hs_gap <= GAP_TOP;
      ls_gap <= GAP_TOP;
    end else begin
      hs_q   <= want_hs && !ls_q && gap_done(ls_gap);
      ls_q   <= want_ls && !ls_kill && !hs_q && gap_done(hs_gap);
      hs_gap <= gap_next(hs_gap, hs_q);
      ls_gap <= gap_next(ls_gap, ls_q);
    end
  end
endmodule

// File: rtl/tri_pwm_phase_seq.sv
module tri_pwm_phase_seq
  import tsq_pkg::*;
#(
  parameter int QUAL_CYC  = 5,
  parameter int DEAD_CYC  = 2,
  parameter int BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwm_hi,
  input  logic pwm_lo,
  input  logic zc_det,
  input  logic neg_oc,
  input  logic flt_latched,
  output logic hs_on,
  output logic ls_on,
  output logic sw_hiz
);
  lvl_e lvl_now, lvl_held, lvl_eff;
  logic mid_now, mid_qual, de_mode, de_done;
  logic want_hs, want_ls, ls_kill;

  assign lvl_now = decode_lvl(pwm_hi, pwm_lo);
  assign mid_now = (lvl_now == LV_MID);

  always_ff @(posedge clk) begin
    if (!rst_n)        lvl_held <= LV_MID;
    else if (!mid_now) lvl_held <= lvl_now;
  end

  assign lvl_eff = mid_now ? lvl_held : lvl_now;

  tsq_midqual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .mid_now (mid_now),
    .qual    (mid_qual)
  );

  assign de_mode = flt_latched || mid_qual;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || !de_mode) de_done <= 1'b0;
    else if (zc_det)               de_done <= 1'b1;
  end

  assign want_hs = en && !de_mode && (lvl_eff == LV_HI);
  assign want_ls = en && (de_mode ? (!de_done && !zc_det) : (lvl_eff == LV_LO));

  tsq_nblank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ls_on   (ls_on),
    .neg_oc  (neg_oc),
    .ls_kill (ls_kill)
  );

  tsq_gate #(.DEAD_CYC(DEAD_CYC)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .want_hs (want_hs),
    .want_ls (want_ls),
    .ls_kill (ls_kill),
    .hs_q    (hs_on),
    .ls_q    (ls_on)
  );

  assign sw_hiz = !hs_on && !ls_on;
endmodule

// File: rtl/tsq_check.sv
module tsq_check #(
  parameter int QUAL_CYC = 5,
  parameter int DEAD_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic neg_oc,
  input logic flt_latched,
  input logic hs_on,
  input logic ls_on,
  input logic mid_now,
  input logic mid_qual
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic [DW-1:0] hs_off_run, ls_off_run;
  logic [QW-1:0] mid_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_off_run <= DW'(DEAD_CYC);
      ls_off_run <= DW'(DEAD_CYC);
      mid_run    <= '0;
    end else begin
      hs_off_run <= hs_on ? '0 : ((hs_off_run == DW'(DEAD_CYC)) ? hs_off_run : hs_off_run + 1'b1);
      ls_off_run <= ls_on ? '0 : ((ls_off_run == DW'(DEAD_CYC)) ? ls_off_run : ls_off_run + 1'b1);
      mid_run    <= !mid_now ? '0 : ((mid_run == QW'(QUAL_CYC)) ? mid_run : mid_run + 1'b1);
    end
  end

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on)); // R3

  AST_DISABLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_on && !ls_on)); // R1

  AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> (ls_off_run >= DW'(DEAD_CYC))); // R4

  AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> (hs_off_run >= DW'(DEAD_CYC))); // R4

  AST_FAULT_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    flt_latched |=> !hs_on); // R9

  AST_NEG_TRIP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && neg_oc) |=> !ls_on); // R8

  AST_QUAL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mid_qual |-> (mid_now && (mid_run >= QW'(QUAL_CYC - 1)))); // R6
endmodule

bind tri_pwm_phase_seq tsq_check #(.QUAL_CYC(QUAL_CYC), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .neg_oc      (neg_oc),
  .flt_latched (flt_latched),
  .hs_on       (hs_on),
  .ls_on       (ls_on),
  .mid_now     (mid_now),
  .mid_qual    (mid_qual)
);

// File: tb/sim_tri_pwm_phase_seq.sv
`timescale 1ns/1ps
module sim_tri_pwm_phase_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pwm_hi = 1'b0, pwm_lo = 1'b0, zc_det = 1'b0, neg_oc = 1'b0, flt_latched = 1'b0;
  logic hs_on, ls_on, sw_hiz;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tri_pwm_phase_seq #(.QUAL_CYC(5), .DEAD_CYC(2), .BLANK_CYC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .zc_det(zc_det), .neg_oc(neg_oc), .flt_latched(flt_latched),
    .hs_on(hs_on), .ls_on(ls_on), .sw_hiz(sw_hiz)
  );

  // {en,hi,lo,zc,noc,flt} edges {exp_hs,exp_ls} req
  localparam int NV = 24;
  localparam logic [15:0] VEC [NV] = '{
    {6'b110000, 4'd3, 2'b10, 4'd2},   // R2 high level
    {6'b101000, 4'd3, 2'b01, 4'd2},   // R2 low level
    {6'b110000, 4'd3, 2'b10, 4'd2},   // R2 back to high
    {6'b100000, 4'd4, 2'b10, 4'd5},   // R5 mid one edge short
    {6'b110000, 4'd1, 2'b10, 4'd5},   // R5 back to high, count restarts
    {6'b100000, 4'd5, 2'b00, 4'd6},   // R6 qualified, HS off
    {6'b100000, 4'd2, 2'b01, 4'd7},   // R7 LS on after dead time
    {6'b100100, 4'd1, 2'b00, 4'd7},   // R7 zero current
    {6'b100000, 4'd3, 2'b00, 4'd7},   // R7 stays floating
    {6'b101000, 4'd3, 2'b01, 4'd7},   // R7 leave mid band
    {6'b101010, 4'd1, 2'b00, 4'd8},   // R8 trip
    {6'b101000, 4'd2, 2'b00, 4'd8},   // R8 still blanked
    {6'b101000, 4'd1, 2'b00, 4'd8},   // R8 last blank cycle
    {6'b101000, 4'd1, 2'b01, 4'd8},   // R8 resumes
    {6'b110001, 4'd3, 2'b01, 4'd9},   // R9 fault over high PWM
    {6'b110101, 4'd1, 2'b00, 4'd9},   // R9 zero current under fault
    {6'b110001, 4'd3, 2'b00, 4'd9},   // R9 stays off
    {6'b110000, 4'd3, 2'b10, 4'd9},   // R9 fault cleared
    {6'b010000, 4'd1, 2'b00, 4'd1},   // R1 disable
    {6'b001000, 4'd3, 2'b00, 4'd1},   // R1 disable with low level
    {6'b111000, 4'd3, 2'b10, 4'd11},  // R11 both flags -> high
    {6'b100000, 4'd3, 2'b10, 4'd11},  // R11 no flag is mid, short
    {6'b100000, 4'd2, 2'b00, 4'd11},  // R11 no flag qualifies
    {6'b101000, 4'd3, 2'b01, 4'd11}   // R11 low over mid
  };

  task automatic check(input logic ehs, input logic els, input int req, input string what);
    logic ehz;
    ehz = !(ehs || els);
    n_chk++;
    if (hs_on !== ehs || ls_on !== els || sw_hiz !== ehz) begin
      n_bad++;
      $display("FAIL R%0d %s: hs/ls/hiz=%b%b%b expected %b%b%b",
               req, what, hs_on, ls_on, sw_hiz, ehs, els, ehz);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 1'b0, 10, "reset state"); // R10
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {en, pwm_hi, pwm_lo, zc_det, neg_oc, flt_latched} = VEC[i][15:10];
      repeat (int'(VEC[i][9:6])) @(posedge clk);
      @(negedge clk);
      check(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R4 / R12: step a low-to-high change edge by edge
    {en, pwm_hi, pwm_lo, zc_det, neg_oc, flt_latched} = 6'b110000;
    @(posedge clk); @(negedge clk);
    check(1'b0, 1'b0, 4, "dead edge 1");
    @(posedge clk); @(negedge clk);
    check(1'b0, 1'b0, 4, "dead edge 2");
    @(posedge clk); @(negedge clk);
    check(1'b1, 1'b0, 12, "high side after gap");

    // R10: reset in the middle of a run
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1'b0, 1'b0, 10, "reset mid-run");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1'b1, 1'b0, 2, "restart after reset");

    finish_run();
  end
endmodule